// File: doc/BRIEF.md
# Start-Triggered Step Counter Controller

This block pairs a small three-state controller with a 4-bit counter and two flag bits, an "early" flag and a "finished" flag. The controller sits idle until a start pulse arrives. Start clears the counter and the finished flag. The controller then counts up once per clock. While it counts, the counter's upper bits steer the early flag and decide when to stop.

When the two upper counter bits are both 1, the controller spends exactly one clock in a closing state. In that state it raises the finished flag. It then returns to idle and waits for the next start. All of a state's register updates, conditional ones included, land on the same clock edge as the state change. Every decision is made on the counter value from before that edge's increment.

The state code is brought out on a 2-bit port: idle = 00, counting = 01, closing = 11. Code 10 is never used.

Top module: `start_count_ctrl`

## Requirements
- R1: In idle (state 00) with start low, the counter, the finished flag, the early flag and the state all stay unchanged on each clock.
- R2: In idle with start high, the next edge sets the counter to 0, clears the finished flag and moves to counting (01). The early flag is left unchanged.
- R3: In counting, the counter increases by one (modulo 16) on every clock edge.
- R4: In counting, each edge loads the early flag with counter bit 2 (the third bit from the LSB), taken from the value before that edge's increment.
- R5: In counting, the controller moves to closing (11) on an edge where counter bits 2 and 3 are both 1 before the increment. Otherwise it stays in counting.
- R6: Closing lasts exactly one clock. Its edge sets the finished flag, keeps the counter and the early flag unchanged, and returns to idle.
- R7: After a start, the controller stays in counting for exactly 13 clocks and reaches closing with the counter at 13.
- R8: Start has no effect in counting or closing.
- R9: The state output only ever shows 00, 01 or 11. The code 10, if it ever occurs, leads to idle on the next clock.
- R10: An active-low asynchronous reset puts the controller in idle with the counter, the early flag and the finished flag at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins an operation cycle when sampled high in idle |
| count | output | 4 | Counter value, bit 0 is the LSB |
| flag_e | output | 1 | Early flag, follows counter bit 2 during counting |
| flag_f | output | 1 | Finished flag, set in closing, cleared by start |
| state | output | 2 | Controller state code (00 idle, 01 counting, 11 closing) |

## Verification
The bench compares every clock against a cycle model derived from the requirements. It runs idle periods, single start pulses, start held high for many operation cycles, and a sparse periodic start pattern.

It targets four faults:
- Decisions made on the post-increment counter value: the early flag would rise one count early, and closing would be entered at count 12 instead of 13.
- A stop test on bit 2 alone: counting would end after 5 clocks.
- Start not ignored outside idle: the counter would restart in the middle of a run.
- A start that fails to clear the finished flag: the flag would stay high throughout the next run.

// File: rtl/start_count_ctrl.sv
module start_count_ctrl #(
  parameter int CNT_W     = 4,
  parameter int STEER_BIT = 2,
  parameter int STOP_BIT  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic [CNT_W-1:0] count,
  output logic             flag_e,
  output logic             flag_f,
  output logic [1:0]       state
);
  localparam logic [1:0] S_IDLE  = 2'b00;
  localparam logic [1:0] S_COUNT = 2'b01;
  localparam logic [1:0] S_CLOSE = 2'b11;

  logic steer, stop;
  assign steer = count[STEER_BIT];
  assign stop  = steer & count[STOP_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      count  <= '0;
      flag_e <= 1'b0;
      flag_f <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          count  <= '0;
          flag_f <= 1'b0;
          state  <= S_COUNT;
        end
        S_COUNT: begin
          count  <= count + 1'b1;
          flag_e <= steer;
          if (stop) state <= S_CLOSE;
        end
        S_CLOSE: begin
          flag_f <= 1'b1;
          state  <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && !start) |=> (state == S_IDLE && $stable(count) && $stable(flag_f))); // R1
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && start) |=> (state == S_COUNT && count == '0 && !flag_f)); // R2
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_COUNT) |=> (count == $past(count) + 1'b1)); // R3
  AST_E_STEER: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_COUNT) |=> (flag_e == $past(count[STEER_BIT]))); // R4
  AST_CLOSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_CLOSE) |=> (state == S_IDLE && flag_f && $stable(count))); // R6
  AST_NO_CODE_10: assert property (@(posedge clk) disable iff (!rst_n)
    state != 2'b10); // R9
endmodule

// File: tb/start_count_ctrl_test.sv
module start_count_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [3:0] count;
  logic flag_e, flag_f;
  logic [1:0] state;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [1:0] m_st;
  logic [3:0] m_a;
  logic m_e, m_f;

  start_count_ctrl uut (.clk(clk), .rst_n(rst_n), .start(start), .count(count),
                        .flag_e(flag_e), .flag_f(flag_f), .state(state));

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    chk({tag, " state"}, {6'd0, state}, {6'd0, m_st});
    chk({tag, " count"}, {4'd0, count}, {4'd0, m_a});
    chk({tag, " flag_e"}, {7'd0, flag_e}, {7'd0, m_e});
    chk({tag, " flag_f"}, {7'd0, flag_f}, {7'd0, m_f});
    chk("R9 code", {7'd0, state == 2'b10}, 8'd0);
  endtask

  task automatic step(input logic s, input string tag);
    start = s;
    case (m_st)
      2'b00: if (s) begin m_a = 4'd0; m_f = 1'b0; m_st = 2'b01; end
      2'b01: begin
        m_e = m_a[2];
        if (m_a[2] && m_a[3]) m_st = 2'b11;
        m_a = m_a + 4'd1;
      end
      2'b11: begin m_f = 1'b1; m_st = 2'b00; end
      default: m_st = 2'b00;
    endcase
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    m_st = 2'b00; m_a = 4'd0; m_e = 1'b0; m_f = 1'b0;
    repeat (2) @(negedge clk);
    compare("R10 reset");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R10 after release");

    for (int i = 0; i < 5; i++) step(1'b0, "R1 idle");

    step(1'b1, "R2 start");
    begin
      int in_count = 1;
      while (state == 2'b01) begin
        step(1'b0, "R3 R4 R5 count");
        if (state == 2'b01) in_count++;
      end
      chk("R7 clocks in counting", in_count[7:0], 8'd13);
      chk("R7 count at closing", {4'd0, count}, 8'd13);
      chk("R6 closing state", {6'd0, state}, 8'h03);
    end
    step(1'b0, "R6 close");
    chk("R6 finished flag", {7'd0, flag_f}, 8'd1);
    for (int i = 0; i < 3; i++) step(1'b0, "R1 idle after run");

    step(1'b1, "R2 restart");
    chk("R2 finished cleared", {7'd0, flag_f}, 8'd0);
    chk("R2 early kept", {7'd0, flag_e}, 8'd1);
    step(1'b1, "R4 early cleared");
    chk("R4 early low at A=0", {7'd0, flag_e}, 8'd0);

    for (int i = 0; i < 60; i++) step(1'b1, "R8 start held");
    for (int i = 0; i < 300; i++) step(i % 7 == 0, "R8 sparse start");
    for (int i = 0; i < 300; i++) step(i % 23 == 3, "R1 R5 pattern");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule